// File: doc/BRIEF.md
# 16-bit Timer/Counter with Atomic Byte Access

This block is a 16-bit timer/counter that sits on an 8-bit register bus. It holds a counter, two compare registers and a capture register. Each of them has a low-byte and a high-byte address. The bus is only 8 bits wide, so every 16-bit transfer takes two byte accesses. A single 8-bit holding latch makes each pair of accesses take effect as one 16-bit operation. A write goes high byte then low byte, and the low-byte write commits all 16 bits. A read goes low byte then high byte, and the low-byte read freezes the high byte in the latch for the read that follows.

The counter advances on a timer tick. A 3-bit select input picks where the tick comes from: it can be stopped, taken from the system clock through a free-running prescaler, or taken from edges on an external pin that is synchronized into the clock domain. The counter counts up by default and down when the direction input is high. Two sticky flags record a match between the counter and either compare register. A strobe input copies the counter into the capture register.

Top module: `tmr16_top`

## Requirements
- R1: A bus write to a high-byte address (address bit 0 = 1) loads only the shared holding latch and leaves the addressed 16-bit register unchanged.
- R2: A bus write to a low-byte address (address bit 0 = 0) loads the addressed register with {latch, written byte} at that clock edge. Register index = address bits [2:1]: 0 counter, 1 compare A, 2 compare B, 3 capture.
- R3: A read of a low-byte address returns the register's low byte in the same cycle, and at that clock edge copies the register's high byte into the latch.
- R4: A read of a high-byte address returns the latch contents, not the live high byte.
- R5: One latch serves all four registers. A high-byte write to one register changes what a following high-byte read of another register returns.
- R6: After reset the counter, both compare registers, the capture register and both match flags are zero.
- R7: The clock select works as follows. 0 stops the counter. 1 ticks on every clock. 2, 3, 4 and 5 tick once every 8, 64, 256 and 1024 clocks of a free-running prescaler. Over any window whose length is a multiple of the division, the counter advances by exactly window/division.
- R8: Select 6 counts falling edges and select 7 counts rising edges of the external pin. The pin passes through two synchronizer flops, so the count changes within three clocks of the edge. No other input gates these edges.
- R9: A low-byte counter write takes priority over a tick in the same cycle. Counting resumes from the written value on the next tick.
- R10: The counter increments when the direction input is 0 and decrements when it is 1, wrapping modulo 2^16.
- R11: A tick while the counter equals compare A (or B) sets flag A (or B). The flag stays set until its clear strobe is pulsed. If a set and a clear fall in the same cycle, the set wins.
- R12: A capture strobe loads the current counter value into the capture register. Bus writes to the capture low-byte address (6) leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 3 | Byte address: [2:1] register index, [0] high byte |
| bus_wr_i | input | 1 | Byte write strobe |
| bus_rd_i | input | 1 | Byte read strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid in the cycle of the read strobe |
| clk_sel_i | input | 3 | Tick source select |
| ext_pin_i | input | 1 | External count pin (asynchronous) |
| dir_down_i | input | 1 | 1 = count down |
| capture_i | input | 1 | Capture strobe |
| clr_match_a_i | input | 1 | Clear strobe for flag A |
| clr_match_b_i | input | 1 | Clear strobe for flag B |
| match_a_o | output | 1 | Sticky compare-A match flag |
| match_b_o | output | 1 | Sticky compare-B match flag |

## Verification
Two pairs of events can land in the same cycle. The first is a low-byte counter write and a timer tick. The bench provokes it by presetting the counter while the select input is set to tick every clock. It judges the result by reading back the value one tick later, which must be the written value plus one. The second is a compare match and a flag clear strobe. The bench provokes it by holding the clear strobe during the tick on which the counter equals compare A, and the flag must still read set afterwards. Random byte traffic against a bench model of the latch covers accesses that interleave between registers.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned REG_W  = 2 * DATA_W;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned N_REGS = 4;
  localparam int unsigned N_DIVS = 4;

  typedef enum logic [2:0] {
    CS_STOP     = 3'd0,
    CS_DIV1     = 3'd1,
    CS_DIV8     = 3'd2,
    CS_DIV64    = 3'd3,
    CS_DIV256   = 3'd4,
    CS_DIV1024  = 3'd5,
    CS_EXT_FALL = 3'd6,
    CS_EXT_RISE = 3'd7
  } clk_sel_e;

  typedef enum logic [1:0] {
    RG_CNT  = 2'd0,
    RG_CMPA = 2'd1,
    RG_CMPB = 2'd2,
    RG_CAP  = 2'd3
  } reg_idx_e;

  // log2 of each prescaler division, indexed from CS_DIV8 upward
  function automatic int unsigned div_log(int unsigned i);
    case (i)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return 10;
    endcase
  endfunction
endpackage

// File: rtl/tmr16_tick.sv
module tmr16_tick
  import tmr16_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] sel_i,
  input  logic       pin_i,
  output logic       tick_o
);
  localparam int unsigned PSC_W = div_log(N_DIVS - 1);

  logic [PSC_W-1:0]       psc_q;
  logic [N_DIVS-1:0]      tap;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   pin_s, pin_rise, pin_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) psc_q <= '0;
    else         psc_q <= psc_q + 1'b1;
  end

  for (genvar i = 0; i < N_DIVS; i++) begin : g_tap
    localparam int unsigned L = div_log(i);
    assign tap[i] = &psc_q[L-1:0];
  end

  if (SYNC_STAGES == 1) begin : g_sync1
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q <= '0;
      else         sync_q <= pin_i;
    end
  end else begin : g_syncn
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q <= '0;
      else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
    end
  end

  assign pin_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= pin_s;
  end

  assign pin_rise = pin_s & ~prev_q;
  assign pin_fall = ~pin_s & prev_q;

  always_comb begin
    unique case (clk_sel_e'(sel_i))
      CS_STOP:     tick_o = 1'b0;
      CS_DIV1:     tick_o = 1'b1;
      CS_DIV8:     tick_o = tap[0];
      CS_DIV64:    tick_o = tap[1];
      CS_DIV256:   tick_o = tap[2];
      CS_DIV1024:  tick_o = tap[3];
      CS_EXT_FALL: tick_o = pin_fall;
      CS_EXT_RISE: tick_o = pin_rise;
      default:     tick_o = 1'b0;
    endcase
  end

  // R8: an external tick needs the synchronized pin to have moved one clock earlier
  a_r8_ext_tick_follows_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i[2:1] == 2'b11 && tick_o) |-> (pin_s != $past(pin_s)));
endmodule

// File: rtl/tmr16_bus.sv
module tmr16_bus
  import tmr16_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic                         wr_i,
  input  logic                         rd_i,
  input  logic [DATA_W-1:0]            wdata_i,
  input  logic [N_REGS-1:0][REG_W-1:0] regs_i,
  output logic [DATA_W-1:0]            rdata_o,
  output logic [N_REGS-1:0]            load_o,
  output logic [REG_W-1:0]             load_val_o
);
  logic [DATA_W-1:0]  temp_q;
  logic               hi;
  logic [1:0]         idx;
  logic [REG_W-1:0]   sel_reg;

  assign hi      = addr_i[0];
  assign idx     = addr_i[ADDR_W-1:1];
  assign sel_reg = regs_i[idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           temp_q <= '0;
    else if (wr_i && hi)   temp_q <= wdata_i;
    else if (rd_i && !wr_i && !hi) temp_q <= sel_reg[REG_W-1:DATA_W];
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) rdata_o = hi ? temp_q : sel_reg[DATA_W-1:0];
  end

  for (genvar r = 0; r < N_REGS; r++) begin : g_load
    assign load_o[r] = wr_i && !hi && (idx == r[1:0]);
  end
  assign load_val_o = {temp_q, wdata_i};

  // R5: the shared latch only moves on a bus access
  a_r5_temp_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i || rd_i) |=> $stable(temp_q));
  // R4: high-byte read data never depends on the live register
  a_r4_hi_read_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && hi && $past(wr_i) && $past(addr_i[0])) |-> rdata_o == $past(wdata_i));
endmodule

// File: rtl/tmr16_flag.sv
module tmr16_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  a_r11_rise_needs_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(set_i));
  a_r11_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  a_r11_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/tmr16_top.sv
module tmr16_top
  import tmr16_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [2:0]  bus_addr_i,
  input  logic        bus_wr_i,
  input  logic        bus_rd_i,
  input  logic [7:0]  bus_wdata_i,
  output logic [7:0]  bus_rdata_o,
  input  logic [2:0]  clk_sel_i,
  input  logic        ext_pin_i,
  input  logic        dir_down_i,
  input  logic        capture_i,
  input  logic        clr_match_a_i,
  input  logic        clr_match_b_i,
  output logic        match_a_o,
  output logic        match_b_o
);
  logic                         tick;
  logic [REG_W-1:0]             cnt_q, cmp_a_q, cmp_b_q, cap_q;
  logic [N_REGS-1:0][REG_W-1:0] regs;
  logic [N_REGS-1:0]            load;
  logic [REG_W-1:0]             load_val;
  logic                         count_en;

  tmr16_tick #(.SYNC_STAGES(2)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (clk_sel_i),
    .pin_i  (ext_pin_i),
    .tick_o (tick)
  );

  assign regs[RG_CNT]  = cnt_q;
  assign regs[RG_CMPA] = cmp_a_q;
  assign regs[RG_CMPB] = cmp_b_q;
  assign regs[RG_CAP]  = cap_q;

  tmr16_bus u_bus (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (bus_addr_i),
    .wr_i       (bus_wr_i),
    .rd_i       (bus_rd_i),
    .wdata_i    (bus_wdata_i),
    .regs_i     (regs),
    .rdata_o    (bus_rdata_o),
    .load_o     (load),
    .load_val_o (load_val)
  );

  // a preset overrides the tick of the same cycle
  assign count_en = tick && !load[RG_CNT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load[RG_CNT]) cnt_q <= load_val;
    else if (count_en)     cnt_q <= dir_down_i ? cnt_q - 1'b1 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_a_q <= '0;
      cmp_b_q <= '0;
    end else begin
      if (load[RG_CMPA]) cmp_a_q <= load_val;
      if (load[RG_CMPB]) cmp_b_q <= load_val;
    end
  end

  // capture register is not bus-writable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cap_q <= '0;
    else if (capture_i) cap_q <= cnt_q;
  end

  tmr16_flag u_flag_a (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (count_en && (cnt_q == cmp_a_q)),
    .clr_i  (clr_match_a_i),
    .flag_o (match_a_o)
  );

  tmr16_flag u_flag_b (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (count_en && (cnt_q == cmp_b_q)),
    .clr_i  (clr_match_b_i),
    .flag_o (match_b_o)
  );

  a_r1_hi_write_keeps_cnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == 3'd1 && clk_sel_i == CS_STOP) |=> $stable(cnt_q));
  a_r7_stop_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_sel_i == CS_STOP && !(bus_wr_i && bus_addr_i == 3'd0)) |=> $stable(cnt_q));
  a_r9_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == 3'd0) |=> cnt_q[7:0] == $past(bus_wdata_i));
  a_r10_up_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_sel_i == CS_DIV1 && !dir_down_i && !(bus_wr_i && bus_addr_i == 3'd0))
    |=> cnt_q == 16'($past(cnt_q) + 16'd1));
  a_r12_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> cap_q == $past(cnt_q));
  a_r12_no_bus_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!capture_i) |=> $stable(cap_q));
endmodule

// File: tb/tmr16_top_test.sv
module tmr16_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] sel = '0;
  logic       pin = 1'b0, dir = 1'b0, cap = 1'b0, clr_a = 1'b0, clr_b = 1'b0;
  logic       m_a, m_b;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tmr16_top uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .clk_sel_i(sel), .ext_pin_i(pin),
    .dir_down_i(dir), .capture_i(cap), .clr_match_a_i(clr_a), .clr_match_b_i(clr_b),
    .match_a_o(m_a), .match_b_o(m_b)
  );

  function automatic logic [15:0] exp_count(logic [15:0] start, int n, bit down);
    return down ? 16'(start - n) : 16'(start + n);
  endfunction

  function automatic int exp_ticks(int window, int div);
    return window / div;
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr_b(logic [2:0] a, logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_b(logic [2:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(posedge clk); @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic wr16(logic [1:0] idx, logic [15:0] v);
    wr_b({idx, 1'b1}, v[15:8]);
    wr_b({idx, 1'b0}, v[7:0]);
  endtask

  task automatic rd16(logic [1:0] idx, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd_b({idx, 1'b0}, lo);
    rd_b({idx, 1'b1}, hi);
    v = {hi, lo};
  endtask

  task automatic run(logic [2:0] s, int n);
    sel = s;
    repeat (n) @(posedge clk);
    @(negedge clk);
    sel = 3'd0;
  endtask

  task automatic ext_pulses(int n);
    for (int i = 0; i < n; i++) begin
      pin = 1'b1; repeat (4) @(negedge clk);
      pin = 1'b0; repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  b;
    logic [15:0] m [4];
    logic [7:0]  mt;

    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 reset state
    for (int r = 0; r < 4; r++) begin
      rd16(r[1:0], v);
      check("R6 reset value", v, 0);
    end
    check("R6 flag A reset", m_a, 0);
    check("R6 flag B reset", m_b, 0);

    // random byte traffic against a latch model (stop mode: no ticks)
    for (int r = 0; r < 4; r++) m[r] = '0;
    mt = '0;
    for (int k = 0; k < 300; k++) begin
      logic [2:0] a;
      logic [7:0] d;
      a = 3'($urandom % 8);
      d = 8'($urandom % 256);
      if ($urandom % 2) begin
        wr_b(a, d);
        if (a[0]) mt = d;                       // R1
        else if (a[2:1] != 2'd3) m[a[2:1]] = {mt, d}; // R2, R12
      end else begin
        rd_b(a, b);
        if (a[0]) check("R4 random high read", b, mt);
        else begin
          check("R3 random low read", b, m[a[2:1]][7:0]);
          mt = m[a[2:1]][15:8];
        end
      end
    end
    for (int r = 0; r < 4; r++) begin
      rd16(r[1:0], v);
      check("R2 random final value", v, m[r]);
    end

    // R1 high write alone leaves register
    wr16(2'd0, 16'h1234);
    wr_b(3'd1, 8'h99);
    rd16(2'd0, v);
    check("R1 high write no change", v, 16'h1234);

    // R3/R4/R5 latch freeze and sharing
    rd_b(3'd0, b);
    check("R3 low read", b, 8'h34);
    wr_b(3'd3, 8'h77);
    rd_b(3'd1, b);
    check("R5 latch shared across registers", b, 8'h77);
    rd_b(3'd0, b);
    wr16(2'd0, 16'h5600);
    rd_b(3'd1, b);
    check("R4 high read returns frozen latch", b, 8'h56);

    // R7 stop and every-clock counting with carry
    wr16(2'd0, 16'h12FF);
    repeat (5) @(negedge clk);
    rd16(2'd0, v);
    check("R7 stop freezes", v, 16'h12FF);
    run(3'd1, 3);
    rd16(2'd0, v);
    check("R7 div1 counting", v, exp_count(16'h12FF, 3, 0));

    // R7 prescaled modes
    wr16(2'd0, 16'h0000);
    run(3'd2, 64);
    rd16(2'd0, v);
    check("R7 div8", v, exp_ticks(64, 8));
    wr16(2'd0, 16'h0000);
    run(3'd3, 128);
    rd16(2'd0, v);
    check("R7 div64", v, exp_ticks(128, 64));
    wr16(2'd0, 16'h0000);
    run(3'd4, 512);
    rd16(2'd0, v);
    check("R7 div256", v, exp_ticks(512, 256));
    wr16(2'd0, 16'h0000);
    run(3'd5, 2048);
    rd16(2'd0, v);
    check("R7 div1024", v, exp_ticks(2048, 1024));

    // R8 external pin modes
    wr16(2'd0, 16'h0010);
    sel = 3'd7;
    ext_pulses(3);
    sel = 3'd0;
    rd16(2'd0, v);
    check("R8 rising edges", v, 16'h0013);
    sel = 3'd6;
    ext_pulses(2);
    sel = 3'd0;
    rd16(2'd0, v);
    check("R8 falling edges", v, 16'h0015);

    // R9 preset while running
    sel = 3'd1;
    wr_b(3'd1, 8'hAB);
    wr_b(3'd0, 8'hCD);
    @(posedge clk); @(negedge clk);
    sel = 3'd0;
    rd16(2'd0, v);
    check("R9 preset then one tick", v, 16'hABCE);

    // R10 down count with wrap
    wr16(2'd0, 16'h0001);
    dir = 1'b1;
    run(3'd1, 2);
    dir = 1'b0;
    rd16(2'd0, v);
    check("R10 down wrap", v, exp_count(16'h0001, 2, 1));

    // R11 compare flags
    clr_a = 1'b1; clr_b = 1'b1; @(posedge clk); @(negedge clk);
    clr_a = 1'b0; clr_b = 1'b0;
    wr16(2'd1, 16'h0005);
    wr16(2'd2, 16'h0100);
    wr16(2'd0, 16'h0003);
    run(3'd1, 4);
    check("R11 flag A set on match", m_a, 1);
    check("R11 flag B not set", m_b, 0);
    repeat (3) @(negedge clk);
    check("R11 flag A sticky", m_a, 1);
    clr_a = 1'b1; @(posedge clk); @(negedge clk); clr_a = 1'b0;
    check("R11 flag A cleared", m_a, 0);
    wr16(2'd0, 16'h0005);
    clr_a = 1'b1; sel = 3'd1;
    @(posedge clk); @(negedge clk);
    clr_a = 1'b0; sel = 3'd0;
    check("R11 set wins over clear", m_a, 1);
    clr_a = 1'b1; @(posedge clk); @(negedge clk); clr_a = 1'b0;
    check("R11 flag A cleared again", m_a, 0);

    // R12 capture
    wr16(2'd0, 16'h4321);
    cap = 1'b1; @(posedge clk); @(negedge clk); cap = 1'b0;
    rd16(2'd3, v);
    check("R12 capture loads counter", v, 16'h4321);
    wr16(2'd3, 16'hBEEF);
    rd16(2'd3, v);
    check("R12 bus write to capture ignored", v, 16'h4321);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule